// File: doc/BRIEF.md
# Two-Wire Serial Controller Flag Logic

This block keeps the control and status flags of a two-wire serial (SMBus/I2C) controller. The flags record master role, transmit direction, start and stop requests, a pending ACK decision, lost arbitration, the received acknowledge, and a sticky interrupt flag. The bus engine beside it reports single-cycle event pulses. These pulses set or clear the matching flags on the next clock edge. Software writes some flags and clears the interrupt flag through strobes.

Lost arbitration can come from four detected causes. It always drops the master and transmit flags, and it also raises the interrupt flag. When one flag sees a set event and a clear in the same cycle, the set takes effect, so no event is missed. The interrupt output is level-sensitive and gated by an enable input.

Top module: `smb_flag_ctl`

## Requirements
- R1: While `rst_n` is low, every flag and `irq` are 0. After `rst_n` rises, events are ignored on the first two clock edges and take effect from the third. Each flag changes on the clock edge that samples its event.
- R2: `flags` bit positions are: 0 master, 1 transmit, 2 start, 3 stop, 4 ACK-request, 5 arbitration-lost, 6 received-ACK, 7 interrupt. `sw_wr` loads `sw_wdata` into bits 2, 3 and 6 only, and leaves the other bits unchanged.
- R3: The master flag sets on `ev_start_gen`. It clears on `ev_stop_gen` or on lost arbitration.
- R4: On `ev_frame_beg`, the transmit flag sets if `data_wr` pulsed since the previous frame start (the same cycle counts) and clears otherwise. It also clears on `ev_start_det` or on lost arbitration.
- R5: The start flag sets on `ev_addr_rx`. Otherwise only software changes it.
- R6: The stop flag sets on `ev_stop_slv` or on `ev_stray_stop` while master. It clears on `ev_stop_gen`.
- R7: The ACK-request flag sets on `ev_rx_done` only while `hw_ack_en` is 0. It clears on `ev_ack_cycle`.
- R8: Arbitration is lost on any of four causes: `ev_rep_start` while master with the start flag 0; `ev_scl_conflict`; `ev_sda_conflict`; or `ev_stray_stop` while master. Lost arbitration sets the arbitration-lost flag, which clears only on `sw_irq_clr`. `ev_rep_start` has no effect when not master or when the start flag is 1.
- R9: On `ev_tx_done`, the received-ACK flag becomes 1 if `ack_line` is 0 and becomes 0 if `ack_line` is 1.
- R10: The interrupt flag sets on any of these: `ev_start_gen`, lost arbitration, `ev_tx_done`, `ev_rx_done`, `ev_addr_rx` or `ev_stop_slv`. Only `sw_irq_clr` clears it.
- R11: A hardware set event wins over a hardware clear, a software write or a software clear of the same flag in the same cycle.
- R12: `irq` is 1 exactly when the interrupt flag is 1 and `irq_en` is 1, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ev_start_gen | input | 1 | this controller generated a START |
| ev_start_det | input | 1 | a START was seen on the bus |
| ev_addr_rx | input | 1 | START plus address byte received |
| ev_stop_gen | input | 1 | this controller generated a STOP |
| ev_stop_slv | input | 1 | STOP seen while addressed as slave |
| ev_stray_stop | input | 1 | STOP seen during a frame |
| ev_rep_start | input | 1 | repeated START seen on the bus |
| ev_scl_conflict | input | 1 | SCL low while driving a STOP or repeated START |
| ev_sda_conflict | input | 1 | SDA low while sending a 1 outside an ACK slot |
| ev_frame_beg | input | 1 | a data frame is starting |
| data_wr | input | 1 | data register write strobe |
| ev_tx_done | input | 1 | byte sent and ACK slot sampled |
| ack_line | input | 1 | sampled SDA level in the ACK slot |
| ev_rx_done | input | 1 | byte received |
| ev_ack_cycle | input | 1 | ACK slot finished |
| hw_ack_en | input | 1 | automatic ACK enabled |
| sw_wr | input | 1 | software flag write strobe |
| sw_wdata | input | 8 | software write data, by flag position |
| sw_irq_clr | input | 1 | software interrupt clear strobe |
| irq_en | input | 1 | interrupt enable |
| flags | output | 8 | flag register |
| irq | output | 1 | level interrupt request |

## Verification
Directed sequences take each flag through its own set and clear events one at a time. This separates the events that share a flag, such as the four arbitration causes and the two ACK-line values. Collision cycles then pair a set event with a clear or software write of the same flag, which tells set priority apart from clear priority. A qualified repeated START is tried both with and without master role and start flag, to separate a real loss from an ignored event. A long phase of sparse pseudo-random pulses then catches wrong interactions between flags that share causes. It also contains a reset in mid-run, which tests the two-edge release delay.

// File: rtl/smb_flag_pkg.sv
package smb_flag_pkg;
  localparam int NFLAG   = 8;
  localparam int F_MSTR  = 0;
  localparam int F_XMIT  = 1;
  localparam int F_STA   = 2;
  localparam int F_STO   = 3;
  localparam int F_ACKRQ = 4;
  localparam int F_ARBL  = 5;
  localparam int F_RXACK = 6;
  localparam int F_IRQ   = 7;
  localparam int RST_STAGES = 2;

  // Bits software may load through the write strobe
  localparam logic [NFLAG-1:0] SW_WR_MASK =
    NFLAG'((1 << F_STA) | (1 << F_STO) | (1 << F_RXACK));
  // Bits dropped by the software interrupt clear
  localparam logic [NFLAG-1:0] IRQCLR_MASK =
    NFLAG'((1 << F_IRQ) | (1 << F_ARBL));
endpackage

// File: rtl/smb_flag_rstsync.sv
module smb_flag_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/smb_flag_cell.sv
module smb_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic swe_i,
  input  logic swd_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  // hardware set beats hardware clear beats software access
  always_comb begin
    en  = set_i | clr_i | swe_i;
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
    else if (swe_i) q_d = swd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/smb_flag_arb.sv
module smb_flag_arb (
  input  logic rep_start,
  input  logic scl_conflict,
  input  logic sda_conflict,
  input  logic stray_stop,
  input  logic master_q,
  input  logic start_q,
  output logic arb_o,
  output logic arb_stop_o
);
  logic rep_lost;

  always_comb begin
    rep_lost   = rep_start & master_q & ~start_q;
    arb_stop_o = stray_stop & master_q;
    arb_o      = rep_lost | scl_conflict | sda_conflict | arb_stop_o;
  end
endmodule

// File: rtl/smb_flag_txsel.sv
module smb_flag_txsel (
  input  logic clk,
  input  logic rst_n,
  input  logic data_wr,
  input  logic frame_beg,
  input  logic start_det,
  input  logic arb,
  output logic xm_set,
  output logic xm_clr
);
  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic wrote;

  always_comb begin
    wrote   = pend_q | data_wr;
    pend_en = frame_beg | data_wr;
    pend_d  = frame_beg ? 1'b0 : 1'b1;
    xm_set  = frame_beg & wrote;
    xm_clr  = (frame_beg & ~wrote) | start_det | arb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/smb_flag_ctl.sv
module smb_flag_ctl
  import smb_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_gen,
  input  logic             ev_start_det,
  input  logic             ev_addr_rx,
  input  logic             ev_stop_gen,
  input  logic             ev_stop_slv,
  input  logic             ev_stray_stop,
  input  logic             ev_rep_start,
  input  logic             ev_scl_conflict,
  input  logic             ev_sda_conflict,
  input  logic             ev_frame_beg,
  input  logic             data_wr,
  input  logic             ev_tx_done,
  input  logic             ack_line,
  input  logic             ev_rx_done,
  input  logic             ev_ack_cycle,
  input  logic             hw_ack_en,
  input  logic             sw_wr,
  input  logic [NFLAG-1:0] sw_wdata,
  input  logic             sw_irq_clr,
  input  logic             irq_en,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic             rst_q;
  logic             arb;
  logic             arb_stop;
  logic             xm_set;
  logic             xm_clr;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] swe_v;
  logic [NFLAG-1:0] swd_v;
  logic [NFLAG-1:0] q_v;

  smb_flag_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  smb_flag_arb u_arb (
    .rep_start(ev_rep_start), .scl_conflict(ev_scl_conflict),
    .sda_conflict(ev_sda_conflict), .stray_stop(ev_stray_stop),
    .master_q(q_v[F_MSTR]), .start_q(q_v[F_STA]),
    .arb_o(arb), .arb_stop_o(arb_stop)
  );

  smb_flag_txsel u_tx (
    .clk(clk), .rst_n(rst_q), .data_wr(data_wr), .frame_beg(ev_frame_beg),
    .start_det(ev_start_det), .arb(arb), .xm_set(xm_set), .xm_clr(xm_clr)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_MSTR]  = ev_start_gen;
    clr_v[F_MSTR]  = ev_stop_gen | arb;
    set_v[F_XMIT]  = xm_set;
    clr_v[F_XMIT]  = xm_clr;
    set_v[F_STA]   = ev_addr_rx;
    set_v[F_STO]   = ev_stop_slv | arb_stop;
    clr_v[F_STO]   = ev_stop_gen;
    set_v[F_ACKRQ] = ev_rx_done & ~hw_ack_en;
    clr_v[F_ACKRQ] = ev_ack_cycle;
    set_v[F_ARBL]  = arb;
    set_v[F_RXACK] = ev_tx_done & ~ack_line;
    clr_v[F_RXACK] = ev_tx_done & ack_line;
    set_v[F_IRQ]   = ev_start_gen | arb | ev_tx_done | ev_rx_done |
                     ev_addr_rx | ev_stop_slv;
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    assign swe_v[gi] = (SW_WR_MASK[gi] & sw_wr) | (IRQCLR_MASK[gi] & sw_irq_clr);
    assign swd_v[gi] = SW_WR_MASK[gi] & sw_wdata[gi];
    smb_flag_cell u_cell (
      .clk(clk), .rst_n(rst_q), .set_i(set_v[gi]), .clr_i(clr_v[gi]),
      .swe_i(swe_v[gi]), .swd_i(swd_v[gi]), .q_o(q_v[gi])
    );
  end

  assign flags = q_v;
  assign irq   = q_v[F_IRQ] & irq_en;
endmodule

// File: rtl/smb_flag_chk.sv
module smb_flag_chk
  import smb_flag_pkg::*;
(
  input logic             clk,
  input logic             rst_ok,
  input logic             ev_start_gen,
  input logic             ev_addr_rx,
  input logic             ev_scl_conflict,
  input logic             ev_rx_done,
  input logic             hw_ack_en,
  input logic             ev_tx_done,
  input logic             ack_line,
  input logic             sw_wr,
  input logic [NFLAG-1:0] sw_wdata,
  input logic             sw_irq_clr,
  input logic             irq_en,
  input logic [NFLAG-1:0] flags,
  input logic             irq
);
  p_mstr_set_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_start_gen |=> flags[F_MSTR]);

  p_sta_set_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_addr_rx |=> flags[F_STA]);

  p_ackrq_auto_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_rx_done && hw_ack_en && !flags[F_ACKRQ] |=> !flags[F_ACKRQ]);

  p_scl_drops_mstr_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_scl_conflict && !ev_start_gen |=> !flags[F_MSTR]);

  p_arbl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    flags[F_ARBL] && !sw_irq_clr |=> flags[F_ARBL]);

  p_rxack_nack_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_tx_done && ack_line |=> !flags[F_RXACK]);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    flags[F_IRQ] && !sw_irq_clr |=> flags[F_IRQ]);

  p_arb_irq_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(flags[F_ARBL]) |-> flags[F_IRQ]);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_tx_done && !ack_line && sw_wr && !sw_wdata[F_RXACK] |=> flags[F_RXACK]);

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    irq |-> irq_en);
endmodule

bind smb_flag_ctl smb_flag_chk u_chk (
  .clk(clk), .rst_ok(rst_q), .ev_start_gen(ev_start_gen), .ev_addr_rx(ev_addr_rx),
  .ev_scl_conflict(ev_scl_conflict), .ev_rx_done(ev_rx_done), .hw_ack_en(hw_ack_en),
  .ev_tx_done(ev_tx_done), .ack_line(ack_line), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
  .sw_irq_clr(sw_irq_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
);

// File: tb/smb_flag_ctl_bench.sv
module smb_flag_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start_gen = 0, ev_start_det = 0, ev_addr_rx = 0, ev_stop_gen = 0;
  logic ev_stop_slv = 0, ev_stray_stop = 0, ev_rep_start = 0, ev_scl_conflict = 0;
  logic ev_sda_conflict = 0, ev_frame_beg = 0, data_wr = 0, ev_tx_done = 0;
  logic ack_line = 0, ev_rx_done = 0, ev_ack_cycle = 0, hw_ack_en = 0;
  logic sw_wr = 0, sw_irq_clr = 0, irq_en = 1;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] flags;
  logic irq;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit m [8];
  bit m_pend;
  int sync_cnt;

  always #10 clk = ~clk;

  smb_flag_ctl u_smb_flag_ctl (.*);

  function automatic string tag_of(int i);
    case (i)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R10";
    endcase
  endfunction

  // reference model: effect of each event on each flag
  always @(negedge rst_n) begin
    foreach (m[i]) m[i] = 0;
    m_pend = 0;
    sync_cnt = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      sync_cnt = 0;
      foreach (m[i]) m[i] = 0;
      m_pend = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      bit lost, stray_arb, wrote;
      bit n [8];
      stray_arb = ev_stray_stop && m[0];
      lost = (ev_rep_start && m[0] && !m[2]) || ev_scl_conflict ||
             ev_sda_conflict || stray_arb;
      wrote = m_pend || data_wr;
      n = m;
      if (sw_wr) begin n[2] = sw_wdata[2]; n[3] = sw_wdata[3]; n[6] = sw_wdata[6]; end
      if (sw_irq_clr) begin n[7] = 0; n[5] = 0; end
      if (ev_stop_gen || lost) n[0] = 0;
      if (ev_start_gen) n[0] = 1;
      if (ev_start_det || lost || (ev_frame_beg && !wrote)) n[1] = 0;
      if (ev_frame_beg && wrote) n[1] = 1;
      if (ev_addr_rx) n[2] = 1;
      if (ev_stop_gen) n[3] = 0;
      if (ev_stop_slv || stray_arb) n[3] = 1;
      if (ev_ack_cycle) n[4] = 0;
      if (ev_rx_done && !hw_ack_en) n[4] = 1;
      if (lost) n[5] = 1;
      if (ev_tx_done) n[6] = !ack_line;
      if (ev_start_gen || lost || ev_tx_done || ev_rx_done || ev_addr_rx || ev_stop_slv)
        n[7] = 1;
      if (ev_frame_beg) m_pend = 0;
      else if (data_wr) m_pend = 1;
      m = n;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 8; i++) begin
        total++;
        if (flags[i] !== m[i]) begin
          bad++;
          $display("FAIL %s flag bit %0d actual=%b expected=%b t=%0t", tag_of(i), i, flags[i], m[i], $time);
        end
      end
      total++;
      if (irq !== (m[7] & irq_en)) begin
        bad++;
        $display("FAIL R12 irq actual=%b expected=%b t=%0t", irq, m[7] & irq_en, $time);
      end
    end
  end

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic clr_pulses();
    ev_start_gen = 0; ev_start_det = 0; ev_addr_rx = 0; ev_stop_gen = 0;
    ev_stop_slv = 0; ev_stray_stop = 0; ev_rep_start = 0; ev_scl_conflict = 0;
    ev_sda_conflict = 0; ev_frame_beg = 0; data_wr = 0; ev_tx_done = 0;
    ev_rx_done = 0; ev_ack_cycle = 0; sw_wr = 0; sw_irq_clr = 0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
    clr_pulses();
    @(negedge clk);
  endtask

  task automatic expect_bit(string rq, int idx, bit v);
    total++;
    if (flags[idx] !== v) begin
      bad++;
      $display("FAIL %s bit %0d actual=%b expected=%b", rq, idx, flags[idx], v);
    end
  endtask

  task automatic expect_irq(string rq, bit v);
    total++;
    if (irq !== v) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", rq, irq, v);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    for (int i = 0; i < 8; i++) expect_bit("R1", i, 0);
    expect_irq("R1", 0);
    repeat (3) @(posedge clk);

    // R3 R10 R12: start generated
    drv(); ev_start_gen = 1; settle();
    expect_bit("R3", 0, 1); expect_bit("R10", 7, 1); expect_irq("R12", 1);
    drv(); irq_en = 0; @(negedge clk); expect_irq("R12", 0);
    drv(); irq_en = 1; sw_irq_clr = 1; settle();
    expect_bit("R10", 7, 0);
    // R2: software write to master bit ignored
    drv(); sw_wr = 1; sw_wdata = 8'h00; settle();
    expect_bit("R2", 0, 1);
    // R4: transmit direction
    drv(); data_wr = 1; settle();
    drv(); ev_frame_beg = 1; settle();
    expect_bit("R4", 1, 1);
    drv(); ev_frame_beg = 1; settle();
    expect_bit("R4", 1, 0);
    // R9: ACK slot value
    drv(); ev_tx_done = 1; ack_line = 0; settle();
    expect_bit("R9", 6, 1);
    drv(); ev_tx_done = 1; ack_line = 1; settle();
    expect_bit("R9", 6, 0);
    // R7: ack request only without automatic ACK
    drv(); ev_rx_done = 1; hw_ack_en = 0; settle();
    expect_bit("R7", 4, 1);
    drv(); ev_ack_cycle = 1; settle();
    expect_bit("R7", 4, 0);
    drv(); ev_rx_done = 1; hw_ack_en = 1; settle();
    expect_bit("R7", 4, 0);
    hw_ack_en = 0;
    // R8: repeated start as master, start flag 0
    drv(); sw_irq_clr = 1; settle();
    drv(); ev_rep_start = 1; settle();
    expect_bit("R8", 5, 1); expect_bit("R8", 0, 0); expect_bit("R10", 7, 1);
    drv(); sw_irq_clr = 1; settle();
    expect_bit("R8", 5, 0);
    // R8: repeated start when not master is ignored
    drv(); ev_rep_start = 1; settle();
    expect_bit("R8", 5, 0);
    // R5: start flag; R8 repeated start with start flag 1 ignored
    drv(); ev_addr_rx = 1; settle();
    expect_bit("R5", 2, 1);
    drv(); ev_start_gen = 1; settle();
    drv(); ev_rep_start = 1; settle();
    expect_bit("R8", 5, 0); expect_bit("R8", 0, 1);
    drv(); sw_wr = 1; sw_wdata = 8'h00; settle();
    expect_bit("R5", 2, 0);
    // R6: stop flag
    drv(); ev_stop_slv = 1; settle();
    expect_bit("R6", 3, 1);
    drv(); ev_stop_gen = 1; settle();
    expect_bit("R6", 3, 0); expect_bit("R3", 0, 0);
    // R6 R8: stray stop while master
    drv(); ev_start_gen = 1; settle();
    drv(); ev_stray_stop = 1; settle();
    expect_bit("R6", 3, 1); expect_bit("R8", 5, 1); expect_bit("R8", 0, 0);
    // R8: data line conflict drops transmit
    drv(); data_wr = 1; ev_frame_beg = 1; settle();
    expect_bit("R4", 1, 1);
    drv(); ev_sda_conflict = 1; settle();
    expect_bit("R8", 1, 0);
    // R11: set beats software write and clear
    drv(); ev_addr_rx = 1; sw_wr = 1; sw_wdata = 8'h00; settle();
    expect_bit("R11", 2, 1);
    drv(); ev_rx_done = 1; sw_irq_clr = 1; settle();
    expect_bit("R11", 7, 1);
    drv(); ev_rx_done = 1; ev_ack_cycle = 1; settle();
    expect_bit("R11", 4, 1);

    // pseudo-random phase with a mid-run reset
    for (int k = 0; k < 4000; k++) begin
      drv();
      clr_pulses();
      if (k == 2000) rst_n = 0;
      if (k == 2003) rst_n = 1;
      ev_start_gen    = ($urandom % 10) == 0;
      ev_start_det    = ($urandom % 14) == 0;
      ev_addr_rx      = ($urandom % 12) == 0;
      ev_stop_gen     = ($urandom % 12) == 0;
      ev_stop_slv     = ($urandom % 14) == 0;
      ev_stray_stop   = ($urandom % 16) == 0;
      ev_rep_start    = ($urandom % 10) == 0;
      ev_scl_conflict = ($urandom % 24) == 0;
      ev_sda_conflict = ($urandom % 24) == 0;
      ev_frame_beg    = ($urandom % 8) == 0;
      data_wr         = ($urandom % 6) == 0;
      ev_tx_done      = ($urandom % 8) == 0;
      ack_line        = $urandom % 2;
      ev_rx_done      = ($urandom % 8) == 0;
      ev_ack_cycle    = ($urandom % 6) == 0;
      hw_ack_en       = ($urandom % 3) == 0;
      sw_wr           = ($urandom % 9) == 0;
      sw_wdata        = 8'($urandom);
      sw_irq_clr      = ($urandom % 5) == 0;
      irq_en          = ($urandom % 4) != 0;
    end
    drv(); clr_pulses();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule